// File: doc/BRIEF.md
# Write-Only I2C Configuration Register Slave

This block is an I2C target for write transfers only. It loads a small bank of control registers from a serial host. Both bus lines first pass through a synchronizer and a stability filter. Short spikes are removed there, so the protocol logic never sees them. The protocol engine detects START, repeated START and STOP. It matches its own device address and drives SDA low through an open-drain enable to acknowledge each accepted byte.

After a matching address, the first byte names the register to start at. Every byte after that is data. Each data byte goes to the current register number, and that number then steps up by one. A repeated START lets the host pick a new starting register within the same message.

An enable input from a supply-good monitor controls the whole slave. While the enable is low, the bus is never driven and every register is held at its default value. The registers appear in parallel on one flat output vector.

Top module: `cfg_wr_slave`

## Requirements
- R1: A level on SCL or SDA that lasts fewer than FILT_N system clocks (default 16, which is 64 ns at 250 MHz) is ignored by the protocol logic.
- R2: An address byte of 0x8C (device address 0x46 in bits 7:1, bit 0 = 0 for write) is acknowledged. The acknowledge is asserted only while the filtered SCL is low. Any other address is not acknowledged, and the rest of that message writes nothing.
- R3: An address byte of 0x8D (a read request to the device address) is not acknowledged.
- R4: The first byte after an acknowledged address is the starting register number. Each following byte is acknowledged and written to the current register number, which then increments by one.
- R5: A repeated START followed by the device address and a new register number redirects the later data bytes, with no STOP in between.
- R6: A data byte aimed at a register number of NREG or above is acknowledged and discarded, and no register changes.
- R7: While `en` is low, `sda_oe` stays 0 and every register holds its default value. Register i defaults to 0x10*(i+1). Synchronous reset also loads the defaults.
- R8: Register i appears on `regs_o[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Supply-good enable; low disables the slave and restores the defaults |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| regs_o | output | NREG*8 | All registers, with register i in bits [8i+7:8i] |

## Verification
A wrong bit counter or phase would show up at the ninth clock of the affected byte: an acknowledge would be missing or misplaced on `sda_oe`. A wrong register-number counter shows up only once the message has written its data, as the wrong byte of `regs_o` changing. A spike that leaks through the filter shifts every later bit, so the data lands wrongly in the same message. An enable that does not fully reset the slave shows up at once, either as a non-default register or as an acknowledge given while disabled.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int SUBW = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/cfg_line_filter.sv
module cfg_line_filter #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic s0, s1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0   <= 1'b1;
      s1   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s0 <= din;
      s1 <= s0;
      if (s1 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(N - 1)) begin
        dout <= s1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: the filtered line only takes a value the synchronized input held
  p_filter_follows_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> (dout == $past(s1)));
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h46
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            scl,
  input  logic            sda,
  output logic            sda_oe,
  output logic            wr,
  output logic [SUBW-1:0] waddr,
  output logic [7:0]      wdata
);
  phase_t          phase;
  logic            scl_q, sda_q;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic            in_ack;
  logic [SUBW-1:0] subaddr;

  logic start_c, stop_c, scl_rise, scl_fall, active;
  assign start_c  = scl_q & scl & sda_q & ~sda;
  assign stop_c   = scl_q & scl & ~sda_q & sda;
  assign scl_rise = ~scl_q & scl;
  assign scl_fall = scl_q & ~scl;
  assign active   = (phase == PH_ADDR) || (phase == PH_SUB) || (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase   <= PH_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bitcnt  <= '0;
      shreg   <= '0;
      in_ack  <= 1'b0;
      sda_oe  <= 1'b0;
      subaddr <= '0;
      wr      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
    end else begin
      wr    <= 1'b0;
      scl_q <= scl;
      sda_q <= sda;
      if (start_c) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        phase  <= PH_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise && !in_ack && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            bitcnt <= '0;
          end else if (bitcnt == 4'd8) begin
            case (phase)
              PH_ADDR: begin
                if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                  sda_oe <= 1'b1;
                  in_ack <= 1'b1;
                  phase  <= PH_SUB;
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_SUB: begin
                subaddr <= shreg[SUBW-1:0];
                sda_oe  <= 1'b1;
                in_ack  <= 1'b1;
                phase   <= PH_DATA;
              end
              default: begin
                wr      <= 1'b1;
                waddr   <= subaddr;
                wdata   <= shreg;
                subaddr <= subaddr + 1'b1;
                sda_oe  <= 1'b1;
                in_ack  <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  // R7: a disabled slave never drives the bus
  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);
  // R2: acknowledge starts only while the filtered clock is low
  p_ack_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl);
  // R4: register writes only come from the data phase
  p_wr_in_data_r4: assert property (@(posedge clk) disable iff (rst)
    wr |-> (phase == PH_DATA));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_i2c_pkg::*;
#(
  parameter int NREG = 8,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [SUBW-1:0]   waddr,
  input  logic [7:0]        wdata,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk) begin
      if (rst || !en)
        r <= DEFAULTS[8*i +: 8];
      else if (wr && waddr == SUBW'(i))
        r <= wdata;
    end
    assign regs_o[8*i +: 8] = r;
  end

  // R6: a write past the last register changes nothing
  p_oob_discard_r6: assert property (@(posedge clk) disable iff (rst)
    (en && wr && waddr >= SUBW'(NREG)) |=> $stable(regs_o));
  // R7: disabled slave holds defaults
  p_defaults_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (regs_o == DEFAULTS));
endmodule

// File: rtl/cfg_wr_slave.sv
module cfg_wr_slave
  import cfg_i2c_pkg::*;
#(
  parameter int NREG = 8,
  parameter int FILT_N = 16,
  parameter logic [6:0] DEV_ADDR = 7'h46,
  parameter logic [NREG*8-1:0] DEFAULTS = 64'h8070_6050_4030_2010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  logic            scl_f, sda_f, wr;
  logic [SUBW-1:0] waddr;
  logic [7:0]      wdata;

  cfg_line_filter #(.N(FILT_N)) u_scl_filt (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f));
  cfg_line_filter #(.N(FILT_N)) u_sda_filt (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f));

  cfg_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .en(en), .scl(scl_f), .sda(sda_f),
    .sda_oe(sda_oe), .wr(wr), .waddr(waddr), .wdata(wdata));

  cfg_regfile #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_regs (
    .clk(clk), .rst(rst), .en(en), .wr(wr), .waddr(waddr),
    .wdata(wdata), .regs_o(regs_o));
endmodule

// File: tb/test_cfg_wr_slave.sv
module test_cfg_wr_slave;
  localparam int NREG = 8;
  localparam int Q = 25;
  localparam logic [63:0] DEF = 64'h8070_6050_4030_2010;
  // {start register, data0, data1}
  localparam logic [23:0] VEC [4] = '{24'h00_A1_A2, 24'h03_B3_B4,
                                      24'h06_C6_C7, 24'h07_D7_D8};

  logic clk = 0, rst = 1, en = 1, scl = 1, tb_sda = 1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  logic [63:0] model;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_wr_slave i_cfg_wr_slave (
    .clk(clk), .rst(rst), .en(en), .scl_i(scl),
    .sda_i(tb_sda & ~sda_oe), .sda_oe(sda_oe), .regs_o(regs_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    tb_sda = 1; wq(); scl = 1; wq(); tb_sda = 0; wq(); scl = 0; wq();
  endtask

  task automatic i2c_stop();
    tb_sda = 0; wq(); scl = 1; wq(); tb_sda = 1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; wq(); scl = 1; wq(2); scl = 0; wq();
    end
    tb_sda = 1; wq(); scl = 1; wq(); ack = sda_oe; wq(); scl = 0; wq();
  endtask

  task automatic put(input logic [7:0] sub, input logic [7:0] d);
    if (sub < NREG) model[8*sub +: 8] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    model = DEF;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (40) @(negedge clk);
    chk("R7 reset defaults", regs_o, DEF);
    chk("R7 reset no ack", sda_oe, 0);

    for (int v = 0; v < 4; v++) begin
      i2c_start();
      send_byte(8'h8C, ack); chk("R2 address ack", ack, 1);
      send_byte(VEC[v][23:16], ack); chk("R4 subaddress ack", ack, 1);
      send_byte(VEC[v][15:8], ack); chk("R4 data0 ack", ack, 1);
      send_byte(VEC[v][7:0], ack);
      chk(VEC[v][23:16] + 1 >= NREG ? "R6 out-of-range ack" : "R4 data1 ack", ack, 1);
      i2c_stop();
      put(VEC[v][23:16], VEC[v][15:8]);
      put(VEC[v][23:16] + 8'd1, VEC[v][7:0]);
      chk("R4 R6 register bank", regs_o, model);
    end
    chk("R8 register 3 slice", regs_o[8*3 +: 8], 8'hB3);

    // R2: foreign address, following bytes ignored
    i2c_start();
    send_byte(8'h8E, ack); chk("R2 foreign address nack", ack, 0);
    send_byte(8'h01, ack); send_byte(8'h55, ack);
    chk("R2 skipped byte nack", ack, 0);
    i2c_stop();
    chk("R2 no write after nack", regs_o, model);

    // R3: read request
    i2c_start();
    send_byte(8'h8D, ack); chk("R3 read nack", ack, 0);
    i2c_stop();

    // R5: repeated start changes subaddress
    i2c_start();
    send_byte(8'h8C, ack); send_byte(8'h01, ack); send_byte(8'hAA, ack);
    i2c_start();
    send_byte(8'h8C, ack); chk("R5 address ack after rstart", ack, 1);
    send_byte(8'h05, ack); send_byte(8'hBB, ack);
    i2c_stop();
    put(8'h01, 8'hAA); put(8'h05, 8'hBB);
    chk("R5 repeated start writes", regs_o, model);

    // R1: short spike on SCL in the low phase before a data byte
    i2c_start();
    send_byte(8'h8C, ack); send_byte(8'h02, ack);
    scl = 1; repeat (8) @(negedge clk); scl = 0; wq();
    send_byte(8'hCC, ack); chk("R1 ack after scl spike", ack, 1);
    i2c_stop();
    put(8'h02, 8'hCC);
    chk("R1 spike ignored", regs_o, model);

    // R7: enable low
    en = 0; repeat (4) @(negedge clk);
    chk("R7 defaults when disabled", regs_o, DEF);
    i2c_start();
    send_byte(8'h8C, ack); chk("R7 no ack when disabled", ack, 0);
    i2c_stop();
    en = 1; repeat (4) @(negedge clk);
    chk("R7 defaults after enable", regs_o, DEF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule